// File: doc/BRIEF.md
# Locking serial command receiver

This block takes commands from a three-wire serial link: an active-low frame select, a serial clock and a serial data line. It runs entirely in the system-clock domain. The three link signals pass through two-flop synchronizers, and edges are detected after synchronization. While a frame is open, a data bit is taken on every falling edge of the serial clock and shifted in most significant bit first.

When the last bit of a frame arrives, the receiver locks. It then presents the upper byte of the frame as a control field and the lower part as a data word, together with a single-cycle valid strobe. It does this at once and does not wait for the select line to rise. Any further serial clocks are ignored until the select line falls again.

If the select line rises before the frame is complete, the partial frame is dropped and nothing is issued. The system clock must run at least four times faster than the serial clock. With the defaults, a frame is 24 bits: an 8-bit control field followed by a 16-bit data word.

Top module: `serial_cmd_rx`

## Requirements
- R1: While rst_ni is low and right after it is released, valid_o is 0 and ctrl_o and data_o are all zeros.
- R2: Bits are taken on falling serial-clock edges, most significant first. The first bit lands in frame bit CTRL_W+DATA_W-1 (23 by default). ctrl_o carries the top CTRL_W frame bits and data_o carries the low DATA_W frame bits.
- R3: The command is issued (valid_o pulses) after the last falling edge of a frame while sel_ni is still low, with no rising select edge needed.
- R4: valid_o is high for exactly one system clock for each accepted frame.
- R5: After a frame locks, further falling serial-clock edges change neither the outputs nor the locked word, and they raise no strobe.
- R6: A rising sel_ni edge before the last bit of a frame aborts it: there is no strobe and ctrl_o and data_o keep their previous values.
- R7: Bits from an aborted frame do not leak into the next frame. The frame after an abort is received exactly.
- R8: A new frame opens only on a falling sel_ni edge. A full frame's worth of serial clocks sent with sel_ni held low after a lock issues nothing.
- R9: ctrl_o and data_o hold their values until the next accepted frame.
- R10: An asynchronous reset in the middle of a frame leaves the receiver idle. With sel_ni still low after the reset, a full frame of clocks issues nothing until sel_ni rises and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Frame select, active low, asynchronous to clk_i |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdi_i | input | 1 | Serial data, most significant bit first |
| valid_o | output | 1 | One-cycle strobe for an accepted frame |
| ctrl_o | output | CTRL_W | Control field of the last accepted frame |
| data_o | output | DATA_W | Data field of the last accepted frame |

## Verification
The bench builds the receiver with a 2-bit control field and a 4-bit data word, so a frame is 6 bits. At that size every one of the 64 frame values can be sent and compared against a split worked out arithmetically in the bench. The short frame also makes it cheap to abort at every possible bit count from zero to five and to confirm that the following frame arrives clean. Post-lock clocks are covered both as a few extra clocks and as a full frame's worth sent with select still low, and a reset in the middle of a frame is covered as well.

// File: rtl/serial_cmd_rx_pkg.sv
package serial_cmd_rx_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // synchronized bus order {sel, sclk, sdi}
  localparam int unsigned SEL_IDX  = 2;
  localparam int unsigned SCLK_IDX = 1;
  localparam int unsigned SDI_IDX  = 0;
endpackage

// File: rtl/serial_cmd_rx_sync.sv
module serial_cmd_rx_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/serial_cmd_rx_edge.sv
module serial_cmd_rx_edge
  import serial_cmd_rx_pkg::*;
#(
  parameter logic RST_VAL = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  lvl_i,
  output edge_t edg_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;

  always_comb begin
    edg_o.rise = ~prev_q & lvl_i;
    edg_o.fall = prev_q & ~lvl_i;
  end
endmodule

// File: rtl/serial_cmd_rx_frame.sv
module serial_cmd_rx_frame
  import serial_cmd_rx_pkg::*;
#(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned FRAME_W = CTRL_W + DATA_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  edge_t              sel_edg_i,
  input  logic               sclk_fall_i,
  input  logic               sdi_i,
  output logic               valid_o,
  output logic [CTRL_W-1:0]  ctrl_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               armed_o,
  output logic               locked_o,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [FRAME_W-1:0] sreg_o
);
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic [CNT_W-1:0]   cnt_q;
  logic               armed_q, locked_q, valid_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  data_q;
  logic               shift_en, last_bit;

  assign sreg_d   = {sreg_q[FRAME_W-2:0], sdi_i};
  assign last_bit = (cnt_q == CNT_W'(FRAME_W - 1));
  // select edges take priority over a coincident serial clock edge
  assign shift_en = armed_q & ~locked_q & sclk_fall_i & ~sel_edg_i.rise & ~sel_edg_i.fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q   <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      valid_q  <= 1'b0;
      ctrl_q   <= '0;
      data_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (sel_edg_i.fall) begin
        armed_q  <= 1'b1;
        locked_q <= 1'b0;
        cnt_q    <= '0;
        sreg_q   <= '0;
      end else if (sel_edg_i.rise) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (shift_en) begin
        sreg_q <= sreg_d;
        if (last_bit) begin
          locked_q <= 1'b1;
          valid_q  <= 1'b1;
          ctrl_q   <= sreg_d[FRAME_W-1 -: CTRL_W];
          data_q   <= sreg_d[DATA_W-1:0];
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign ctrl_o   = ctrl_q;
  assign data_o   = data_q;
  assign armed_o  = armed_q;
  assign locked_o = locked_q;
  assign cnt_o    = cnt_q;
  assign sreg_o   = sreg_q;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import serial_cmd_rx_pkg::*;
#(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FRAME_W = CTRL_W + DATA_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              valid_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] data_o
);
  // sel resets low so a select held low across reset is not seen as a new frame
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0]         raw_w, sync_w;
  edge_t              sel_edg_w, sclk_edg_w;
  logic               armed_w, locked_w;
  logic [CNT_W-1:0]   cnt_w;
  logic [FRAME_W-1:0] sreg_w;

  assign raw_w[SEL_IDX]  = sel_ni;
  assign raw_w[SCLK_IDX] = sclk_i;
  assign raw_w[SDI_IDX]  = sdi_i;

  serial_cmd_rx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_w),
    .q_o   (sync_w)
  );

  serial_cmd_rx_edge #(.RST_VAL(SYNC_RST[SEL_IDX])) u_sel_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_w[SEL_IDX]),
    .edg_o (sel_edg_w)
  );

  serial_cmd_rx_edge #(.RST_VAL(SYNC_RST[SCLK_IDX])) u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_w[SCLK_IDX]),
    .edg_o (sclk_edg_w)
  );

  serial_cmd_rx_frame #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_edg_i  (sel_edg_w),
    .sclk_fall_i(sclk_edg_w.fall),
    .sdi_i      (sync_w[SDI_IDX]),
    .valid_o    (valid_o),
    .ctrl_o     (ctrl_o),
    .data_o     (data_o),
    .armed_o    (armed_w),
    .locked_o   (locked_w),
    .cnt_o      (cnt_w),
    .sreg_o     (sreg_w)
  );

  logic unused_w;
  assign unused_w = sclk_edg_w.rise;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk #(
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned FRAME_W = CTRL_W + DATA_W,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_o,
  input logic [CTRL_W-1:0]  ctrl_o,
  input logic [DATA_W-1:0]  data_o,
  input logic               armed_i,
  input logic               locked_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic [FRAME_W-1:0] sreg_i,
  input logic               sel_rise_i,
  input logic               sel_fall_i
);
  assert_valid_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(ctrl_o) && $stable(data_o)));

  assert_lock_freeze_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_i && !sel_fall_i) |=> $stable(sreg_i));

  assert_abort_silent_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_rise_i && !locked_i) |=> !valid_o);

  assert_valid_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> locked_i);

  assert_idle_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !sel_fall_i) |=> $stable(sreg_i));

  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i < CNT_W'(FRAME_W));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_o   (valid_o),
  .ctrl_o    (ctrl_o),
  .data_o    (data_o),
  .armed_i   (armed_w),
  .locked_i  (locked_w),
  .cnt_i     (cnt_w),
  .sreg_i    (sreg_w),
  .sel_rise_i(sel_edg_w.rise),
  .sel_fall_i(sel_edg_w.fall)
);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
  localparam int CW = 2;
  localparam int DW = 4;
  localparam int FW = CW + DW;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic valid;
  logic [CW-1:0] ctrl;
  logic [DW-1:0] data;

  int checks = 0;
  int errors = 0;
  int vcount = 0;
  int dbl = 0;
  bit prev_v = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_cmd_rx #(.CTRL_W(CW), .DATA_W(DW)) dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .sel_ni (sel_n),
    .sclk_i (sclk),
    .sdi_i  (sdi),
    .valid_o(valid),
    .ctrl_o (ctrl),
    .data_o (data)
  );

  always @(negedge clk) begin
    if (rst_n && valid) begin
      vcount++;
      if (prev_v) dbl++;
    end
    prev_v = rst_n && valid;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sdi = b;
    wclk(HALF);
    sclk = 1'b0;
    wclk(HALF);
    sclk = 1'b1;
  endtask

  // send the top n bits of w, MSB first
  task automatic send(input int w, input int n);
    for (int i = FW - 1; i >= FW - n; i--) bit_out(w[i]);
    wclk(8);
  endtask

  task automatic sel_fall();
    sel_n = 1'b0;
    wclk(HALF);
  endtask

  task automatic sel_rise();
    sel_n = 1'b1;
    wclk(HALF + 4);
  endtask

  task automatic expect_word(input int w, input string req);
    chk(int'(ctrl) == (w / (1 << DW)) % (1 << CW), req, int'(ctrl), (w / (1 << DW)) % (1 << CW));
    chk(int'(data) == w % (1 << DW), req, int'(data), w % (1 << DW));
  endtask

  initial begin
    int base;
    int last;
    wclk(3);
    chk(valid == 1'b0, "R1", int'(valid), 0);
    chk(ctrl == '0 && data == '0, "R1", int'({ctrl, data}), 0);
    rst_n = 1'b1;
    wclk(6);
    chk(valid == 1'b0 && vcount == 0, "R1", vcount, 0);
    chk(ctrl == '0 && data == '0, "R1", int'({ctrl, data}), 0);

    // every frame value; extra clocks after lock
    for (int w = 0; w < (1 << FW); w++) begin
      base = vcount;
      sel_fall();
      send(w, FW);
      chk(vcount == base + 1, "R3", vcount - base, 1);
      expect_word(w, "R2");
      for (int k = 0; k < 3; k++) bit_out(~w[k]);
      wclk(8);
      chk(vcount == base + 1, "R5", vcount - base, 1);
      expect_word(w, "R5");
      sel_rise();
    end
    last = (1 << FW) - 1;

    // abort at every length, then a clean frame
    for (int k = 0; k < FW; k++) begin
      int nw;
      nw = (k * 11 + 5) % (1 << FW);
      base = vcount;
      sel_fall();
      send(~last, k);
      sel_rise();
      chk(vcount == base, "R6", vcount - base, 0);
      expect_word(last, "R9");
      sel_fall();
      send(nw, FW);
      sel_rise();
      chk(vcount == base + 1, "R7", vcount - base, 1);
      expect_word(nw, "R7");
      last = nw;
    end

    // a whole second frame with select still low
    base = vcount;
    sel_fall();
    send(6'h2A, FW);
    send(6'h15, FW);
    chk(vcount == base + 1, "R8", vcount - base, 1);
    expect_word(6'h2A, "R8");
    sel_rise();
    sel_fall();
    send(6'h15, FW);
    sel_rise();
    chk(vcount == base + 2, "R8", vcount - base, 2);
    expect_word(6'h15, "R8");

    // reset mid-frame with select held low
    sel_fall();
    send(6'h3C, 3);
    rst_n = 1'b0;
    wclk(3);
    chk(ctrl == '0 && data == '0 && valid == 1'b0, "R1", int'({ctrl, data}), 0);
    rst_n = 1'b1;
    wclk(4);
    base = vcount;
    send(6'h27, FW);
    chk(vcount == base, "R10", vcount - base, 0);
    chk(ctrl == '0 && data == '0, "R10", int'({ctrl, data}), 0);
    sel_rise();
    sel_fall();
    send(6'h27, FW);
    sel_rise();
    chk(vcount == base + 1, "R10", vcount - base, 1);
    expect_word(6'h27, "R10");

    chk(dbl == 0, "R4", dbl, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule